// File: doc/BRIEF.md
# Active Pixel Capture for a 320x240 Panel

This block sits between a panel's raw video input and its frame buffer. On every video clock it samples a 4-bit pixel, the line and frame syncs and a data-enable line. It then decides, from a 3-bit mode code, whether that sample is a visible pixel and where on a 320x240 grid it belongs. A kept sample leaves as a one-cycle write beat carrying the pixel and its column and row.

Three rules place the first pixel of a line. In the edge rule it is the sample straight after the line sync's leading edge. In the fixed rule it is a set number of clocks after that edge. In the enable rule every sample with data-enable high is a pixel, and the column counts from the start of each enable run. The larger-source modes accept a 640x480 input and keep only its upper-left 320x240 quarter. Samples beyond column 319 or row 239 are dropped in every mode. A self-test code, and the two unused codes, keep the write output silent.

The write output is a valid-only stream with no ready. The video source cannot be stalled, so the sink must take each beat in the cycle it is offered. Nothing is held back for a sink that is slow.

Top module: `active_pixel_capture`

## Requirements
- R1: All four outputs are registered. The result for a sample taken at a clock edge appears just after that same edge, and `out_pix` carries the pixel sampled on that edge.
- R2: The mode codes are: 0 = edge rule; 1 = fixed rule, 320x240 source; 2 = enable rule, 320x240 source; 3 = fixed rule, 640x480 source; 4 = enable rule, 640x480 source; 5 = self-test; 6 and 7 are unused.
- R3: In mode 0, the sample taken on the clock after the `hs_n` falling edge has column 0, and each following sample adds one to the column.
- R4: In modes 1 and 3, `FIX_OFS` samples after the `hs_n` falling edge are skipped, and the next sample has column 0. `de` has no effect in these modes.
- R5: In modes 2 and 4, only samples with `de` high are written. The first sample of each run of `de` high has column 0. `hs_n` does not move the column.
- R6: A sample whose column would be `H_ACTIVE` (320) or more is not written.
- R7: The row resets on the `vs_n` falling edge. In modes 0, 1 and 3, the row is the count of `hs_n` falling edges since then, minus one. In modes 2 and 4, it is the count of `de` falling edges since then. Rows of `V_ACTIVE` (240) or more are not written, which keeps the upper-left quarter of a 640x480 source.
- R8: Under modes 5, 6 and 7, `out_valid` stays low.
- R9: Reset clears all outputs. After reset, nothing is written until a `vs_n` falling edge has been seen.
- R10: The sample on which `vs_n` falls is never written. In modes 0, 1 and 3, the sample on which `hs_n` falls is not written either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Mode code (see R2) |
| hs_n | input | 1 | Line sync, active low; its falling edge starts a line |
| vs_n | input | 1 | Frame sync, active low; its falling edge starts a frame |
| de | input | 1 | Data enable, used in modes 2 and 4 |
| pix_in | input | 4 | Pixel sampled on each clock |
| out_valid | output | 1 | Write beat for the frame buffer, no back-pressure |
| out_x | output | 9 | Column of the written pixel |
| out_y | output | 8 | Row of the written pixel |
| out_pix | output | 4 | Pixel value to write |

## Verification
The bench builds the block with its default parameters: 320 columns, 240 rows and a 16-clock fixed offset. With these values the real panel limits are the ones under test. Lines slightly longer than 320 samples reach the column cut-off in the edge, fixed and enable rules. Frames of 242 very short lines reach the row cut-off under both line-counting rules within a few thousand cycles. The 16-clock offset is long enough that a line shorter than it, or one with enable pulses in the skipped region, shows that the fixed rule counts clocks and ignores `de`.

// File: rtl/apc_pkg.sv
package apc_pkg;

  localparam logic [2:0] M_EDGE = 3'd0;
  localparam logic [2:0] M_QFIX = 3'd1;
  localparam logic [2:0] M_QDE  = 3'd2;
  localparam logic [2:0] M_VFIX = 3'd3;
  localparam logic [2:0] M_VDE  = 3'd4;
  localparam logic [2:0] M_TEST = 3'd5;

  // How the first pixel of a line is located
  typedef enum logic [1:0] {
    START_EDGE,
    START_FIX,
    START_DE,
    START_NONE
  } start_e;

  function automatic start_e start_rule(input logic [2:0] m);
    case (m)
      M_EDGE:         return START_EDGE;
      M_QFIX, M_VFIX: return START_FIX;
      M_QDE, M_VDE:   return START_DE;
      default:        return START_NONE;
    endcase
  endfunction

endpackage

// File: rtl/apc_fall_det.sv
module apc_fall_det #(
  parameter bit IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= sig;
  end

  assign fall = prev & ~sig;
endmodule

// File: rtl/apc_hpos.sv
// Horizontal position of the current sample relative to the line start.
module apc_hpos import apc_pkg::*; #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  start_e           rule,
  input  logic             hs_fall,
  input  logic             de,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] SAT = '1;

  logic [POS_W-1:0] pos_inc;
  assign pos_inc = (pos == SAT) ? SAT : pos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= SAT;
    end else if (rule == START_DE) begin
      pos <= de ? pos_inc : '0;
    end else if (hs_fall) begin
      pos <= '0;
    end else begin
      pos <= pos_inc;
    end
  end
endmodule

// File: rtl/apc_row.sv
// Row index of the current sample within the frame.
module apc_row import apc_pkg::*; #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  start_e           rule,
  input  logic             hs_fall,
  input  logic             vs_fall,
  input  logic             de_fall,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] SAT = '1;

  logic [ROW_W-1:0] row_next;

  function automatic logic [ROW_W-1:0] sat_inc(input logic [ROW_W-1:0] v);
    return (v == SAT) ? SAT : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row      <= SAT;
      row_next <= SAT;
    end else if (vs_fall) begin
      if (rule == START_DE) begin
        row      <= '0;
        row_next <= '0;
      end else begin
        row      <= hs_fall ? '0 : SAT;
        row_next <= hs_fall ? ROW_W'(1) : '0;
      end
    end else if (rule == START_DE) begin
      if (de_fall) row <= sat_inc(row);
    end else if (hs_fall) begin
      row      <= row_next;
      row_next <= sat_inc(row_next);
    end
  end
endmodule

// File: rtl/active_pixel_capture.sv
module active_pixel_capture import apc_pkg::*; #(
  parameter int H_ACTIVE = 320,
  parameter int V_ACTIVE = 240,
  parameter int FIX_OFS  = 16,
  parameter int PIX_W    = 4,
  localparam int X_W     = $clog2(H_ACTIVE),
  localparam int Y_W     = $clog2(V_ACTIVE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             hs_n,
  input  logic             vs_n,
  input  logic             de,
  input  logic [PIX_W-1:0] pix_in,
  output logic             out_valid,
  output logic [X_W-1:0]   out_x,
  output logic [Y_W-1:0]   out_y,
  output logic [PIX_W-1:0] out_pix
);
  localparam int POS_W = $clog2(FIX_OFS + H_ACTIVE + 2) + 1;
  localparam int ROW_W = $clog2(V_ACTIVE + 1) + 1;
  localparam logic [POS_W-1:0] H_LIM   = POS_W'(H_ACTIVE);
  localparam logic [POS_W-1:0] FIX_LIM = POS_W'(FIX_OFS);
  localparam logic [ROW_W-1:0] V_LIM   = ROW_W'(V_ACTIVE);
  localparam int NSYNC = 3;
  // bit 0 = hs_n, bit 1 = vs_n, bit 2 = de; idle levels after reset
  localparam logic [NSYNC-1:0] IDLE_LVL = 3'b011;

  start_e           rule;
  logic [NSYNC-1:0] sync_now, sync_fall;
  logic             hs_fall, vs_fall, de_fall;
  logic [POS_W-1:0] pos, xsel;
  logic [ROW_W-1:0] row;
  logic             hit;

  assign rule     = start_rule(mode);
  assign sync_now = {de, vs_n, hs_n};

  for (genvar g = 0; g < NSYNC; g++) begin : g_fall
    apc_fall_det #(.IDLE(IDLE_LVL[g])) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (sync_now[g]),
      .fall (sync_fall[g])
    );
  end

  assign hs_fall = sync_fall[0];
  assign vs_fall = sync_fall[1];
  assign de_fall = sync_fall[2];

  apc_hpos #(.POS_W(POS_W)) u_hpos (
    .clk    (clk),
    .rst_n  (rst_n),
    .rule   (rule),
    .hs_fall(hs_fall),
    .de     (de),
    .pos    (pos)
  );

  apc_row #(.ROW_W(ROW_W)) u_row (
    .clk    (clk),
    .rst_n  (rst_n),
    .rule   (rule),
    .hs_fall(hs_fall),
    .vs_fall(vs_fall),
    .de_fall(de_fall),
    .row    (row)
  );

  // Per-sample keep decision
  always_comb begin
    hit  = 1'b0;
    xsel = pos;
    case (rule)
      START_EDGE: hit = !hs_fall && (pos < H_LIM);
      START_FIX: begin
        xsel = pos - FIX_LIM;
        hit  = !hs_fall && (pos >= FIX_LIM) && (xsel < H_LIM);
      end
      START_DE:   hit = de && (pos < H_LIM);
      default:    hit = 1'b0;
    endcase
    if (vs_fall || (row >= V_LIM)) hit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_pix   <= '0;
    end else begin
      out_valid <= hit;
      if (hit) begin
        out_x   <= X_W'(xsel);
        out_y   <= Y_W'(row);
        out_pix <= pix_in;
      end
    end
  end
endmodule

// File: rtl/apc_chk.sv
module apc_chk import apc_pkg::*; #(
  parameter int H_ACTIVE = 320,
  parameter int V_ACTIVE = 240,
  parameter int PIX_W    = 4,
  localparam int X_W     = $clog2(H_ACTIVE),
  localparam int Y_W     = $clog2(V_ACTIVE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             de,
  input logic [PIX_W-1:0] pix_in,
  input logic             out_valid,
  input logic [X_W-1:0]   out_x,
  input logic [Y_W-1:0]   out_y,
  input logic [PIX_W-1:0] out_pix
);
  localparam logic [X_W:0] X_LIM = (X_W+1)'(H_ACTIVE);
  localparam logic [Y_W:0] Y_LIM = (Y_W+1)'(V_ACTIVE);

  a_r8_quiet_modes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_TEST || $past(mode) > M_TEST) |-> !out_valid);

  // R6 column cut-off, R7 row cut-off
  a_r6_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_x} < X_LIM) && ({1'b0, out_y} < Y_LIM));

  a_r5_de_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(mode) == M_QDE || $past(mode) == M_VDE)) |-> $past(de));

  a_r1_pix_follow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pix == $past(pix_in)));

  a_r3_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && ($past(mode) == $past(mode, 2)))
      |-> (out_x == X_W'($past(out_x) + 1'b1)));
endmodule

bind active_pixel_capture apc_chk #(
  .H_ACTIVE(H_ACTIVE),
  .V_ACTIVE(V_ACTIVE),
  .PIX_W   (PIX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .de       (de),
  .pix_in   (pix_in),
  .out_valid(out_valid),
  .out_x    (out_x),
  .out_y    (out_y),
  .out_pix  (out_pix)
);

// File: tb/tb_active_pixel_capture.sv
module tb_active_pixel_capture;
  localparam int H   = 320;
  localparam int V   = 240;
  localparam int FIX = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       hs_n = 1'b1, vs_n = 1'b1, de = 1'b0;
  logic [3:0] pix_in = 4'd0;
  logic       out_valid;
  logic [8:0] out_x;
  logic [7:0] out_y;
  logic [3:0] out_pix;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  active_pixel_capture dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hs_n(hs_n), .vs_n(vs_n), .de(de),
    .pix_in(pix_in), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .out_pix(out_pix)
  );

  // mode, de lead, de length, line length, lines, expected writes, tag
  // tag 1=R4 2=R5 3=R6 4=R7 5=R8
  localparam int NROW = 9;
  localparam int TBL [NROW][7] = '{
    '{0, 0,   0, 330,   3,  960, 3},  // R6: edge rule, column cap
    '{1, 0,   0, 340,   2,  640, 1},  // R4: fixed offset, column cap
    '{3, 0,   3,  30,   2,   26, 1},  // R4: de toggles but is ignored
    '{2, 5,  20,  40,   3,   60, 2},  // R5: enable runs
    '{4, 3, 330, 340,   2,  640, 3},  // R6: enable run longer than 320
    '{5, 2,   5,  20,   2,    0, 5},  // R8: self-test
    '{7, 2,   5,  20,   2,    0, 5},  // R8: unused code
    '{0, 0,   0,  10, 242, 2160, 4},  // R7: row cap, sync counting
    '{4, 2,   4,   8, 242,  960, 4}   // R7: row cap, enable counting
  };

  function automatic string tag_of(input int n);
    case (n)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // R10: frame sync samples give no write
  task automatic blank();
    int nv = 0;
    vs_n = 1'b0; hs_n = 1'b1; de = 1'b0; pix_in = 4'd0;
    step(); if (out_valid) nv++;
    step(); if (out_valid) nv++;
    vs_n = 1'b1;
    step(); if (out_valid) nv++;
    step(); if (out_valid) nv++;
    chk(nv == 0, "R10", "writes during frame sync", nv, 0);
  endtask

  task automatic run_frame(input int m, input int lead, input int len,
                           input int llen, input int nlines, input bit with_vs,
                           output int writes);
    mode = m[2:0];
    if (with_vs) blank();
    writes = 0;
    for (int k = 0; k < nlines; k++) begin
      bit    bad = 1'b0;
      int    act = 0, exp = 0, bi = 0;
      string tag;
      for (int i = 0; i < llen; i++) begin
        bit ev;
        int ex;
        hs_n   = (i < 2) ? 1'b0 : 1'b1;
        de     = (len > 0) && (i >= lead) && (i < lead + len);
        pix_in = 4'((i + k) & 15);
        step();
        ev = 1'b0; ex = 0;
        case (m)
          0:       begin ex = i - 1;       ev = (i >= 1) && (ex < H); end
          1, 3:    begin ex = i - 1 - FIX; ev = (ex >= 0) && (ex < H); end
          2, 4:    begin ex = i - lead;    ev = de && (ex < H); end
          default: ev = 1'b0;
        endcase
        if (!with_vs || k >= V) ev = 1'b0;
        if (out_valid) writes++;
        if (!bad && ((out_valid !== ev) ||
                     (ev && (out_x !== 9'(ex) || out_y !== 8'(k) ||
                             out_pix !== 4'((i + k) & 15))))) begin
          bad = 1'b1;
          bi  = i;
          act = int'(out_valid) * 1000000 + int'(out_x) * 1000 + int'(out_y);
          exp = int'(ev) * 1000000 + (ev ? ex : int'(out_x)) * 1000 + (ev ? k : int'(out_y));
        end
      end
      case (m)
        0:       tag = "R3 R1";
        1, 3:    tag = "R4 R1";
        2, 4:    tag = "R5 R1";
        default: tag = "R8";
      endcase
      if (k >= V) tag = "R7";
      chk(!bad, tag, $sformatf("line %0d sample %0d (valid*1e6+x*1e3+y)", k, bi),
          act, exp);
    end
  endtask

  initial begin
    int w;
    // R9: reset state
    repeat (3) step();
    chk(out_valid == 1'b0 && out_x == 9'd0 && out_y == 8'd0 && out_pix == 4'd0,
        "R9", "outputs in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    step();

    for (int r = 0; r < NROW; r++) begin
      run_frame(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], 1'b1, w);
      chk(w == TBL[r][5], $sformatf("R2 %s", tag_of(TBL[r][6])),
          $sformatf("writes per frame, table row %0d", r), w, TBL[r][5]);
    end

    // R10 / R7: vs falling with de high, then row restarts at 0
    mode = 3'd2; hs_n = 1'b1; vs_n = 1'b0; de = 1'b1; pix_in = 4'd5;
    step();
    chk(out_valid == 1'b0, "R10", "write on vs falling sample", int'(out_valid), 0);
    pix_in = 4'd6;
    step();
    chk(out_valid && out_x == 9'd1 && out_y == 8'd0 && out_pix == 4'd6,
        "R7", "row restarted after vs (x*1e3+y)",
        int'(out_x) * 1000 + int'(out_y), 1000);
    de = 1'b0; step();
    vs_n = 1'b1; step();

    // R9: reset mid-frame, then no writes until a new vs edge
    rst_n = 1'b0;
    step(); step();
    chk(out_valid == 1'b0 && out_x == 9'd0 && out_y == 8'd0,
        "R9", "outputs after mid-frame reset", int'(out_valid), 0);
    rst_n = 1'b1;
    step();
    run_frame(0, 0, 0, 10, 3, 1'b0, w);
    chk(w == 0, "R9", "writes before first vs", w, 0);
    run_frame(0, 0, 0, 10, 2, 1'b1, w);
    chk(w == 18, "R9 R3", "writes after vs", w, 18);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule